// File: doc/BRIEF.md
# Shared GPIO / PWM Port

An eight-pin general-purpose I/O port. It holds an output latch and a direction register, and both sit behind a small register bus. Each pin is either an input or a latched output. The four lowest pins can also be taken over by four PWM channels. While a channel is enabled, its PWM output drives the pin and the general-purpose function is pushed aside.

The pad is modelled as separate drive-value and drive-enable signals. Software reads the direction register back unchanged. A data read is assembled per pin: input pins report the sampled pad level, and output pins report the latch.

A write to the latch always lands, even on a pin that a PWM channel owns. That value appears on the pin once the channel is released. After reset every pin is an undriven input.

Top module: `gpio_pwm_port`

## Requirements
- R1: After reset the direction register reads 0x00 and every drive enable (`pin_oe_o`) is 0.
- R2: A write with `sel_i`=1 loads the direction register on the clock edge, and a read with `sel_i`=1 returns it. A direction bit of 1 means output and 0 means input.
- R3: A read with `sel_i`=0 returns `pin_in_i` on every bit whose direction bit is 0.
- R4: A read with `sel_i`=0 returns the latch on every bit whose direction bit is 1. This holds even for pins under PWM control.
- R5: On a pin with its direction bit 1 and no enabled PWM channel, `pin_out_o` equals the latch and `pin_oe_o` is 1.
- R6: On pin n (n from 0 to 3) with `pwm_en_i[n]`=1, `pin_out_o[n]` equals `pwm_val_i[n]` and `pin_oe_o[n]` is 1, whatever the direction bit.
- R7: A write with `sel_i`=0 while a pin is under PWM control updates that pin's latch bit but leaves `pin_out_o` of that pin following the PWM value.
- R8: When `pwm_en_i[n]` drops, the pin returns to the latch value if its direction bit is 1, and it becomes undriven if its direction bit is 0.
- R9: A write with `sel_i`=0 loads the latch even on input pins. The value appears on the pin once the direction bit is set.
- R10: A pin with its direction bit 0 and no enabled PWM channel has `pin_oe_o`=0.

Pins 4 to 7 have no PWM channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the selected register |
| sel_i | input | 1 | Register select: 0 = data latch, 1 = direction |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register (combinational) |
| pwm_en_i | input | 4 | PWM channel enables for pins 3..0 |
| pwm_val_i | input | 4 | PWM channel output levels for pins 3..0 |
| pin_in_i | input | 8 | Sampled pad levels |
| pin_out_o | output | 8 | Pad drive value |
| pin_oe_o | output | 8 | Pad drive enable |

## Verification
The properties take `sel_i`, `wr_en_i` and `wdata_i` to be stable and known around each rising edge. They also take the PWM enables and levels to be synchronous to the same clock, so a channel released on one edge is seen released on the next.

The stimulus changes every input only at the falling edge. It moves PWM enables and register writes in separate cycles or together, on purpose, to reach the case of a write during PWM ownership. It holds `pin_in_i` at fixed patterns that differ from the latch, so a read that picks the wrong source shows up.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic {
    REG_DATA = 1'b0,
    REG_DIR  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             sel_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] data_q_o,
  output logic [WIDTH-1:0] dir_q_o
);
  import gpio_pkg::*;

  logic wr_data, wr_dir;
  assign wr_data = wr_en_i && (reg_sel_e'(sel_i) == REG_DATA);
  assign wr_dir  = wr_en_i && (reg_sel_e'(sel_i) == REG_DIR);

  // latch accepts writes regardless of direction or PWM ownership
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q_o <= '0;
    else if (wr_data) data_q_o <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dir_q_o <= '0;
    else if (wr_dir) dir_q_o <= wdata_i;
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int WIDTH   = 8,
  parameter int NUM_PWM = 4
) (
  input  logic [WIDTH-1:0]   data_q_i,
  input  logic [WIDTH-1:0]   dir_q_i,
  input  logic [NUM_PWM-1:0] pwm_en_i,
  input  logic [NUM_PWM-1:0] pwm_val_i,
  output logic [WIDTH-1:0]   pin_out_o,
  output logic [WIDTH-1:0]   pin_oe_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i < NUM_PWM) begin : g_shared
      assign pin_out_o[i] = pwm_en_i[i] ? pwm_val_i[i] : data_q_i[i];
      assign pin_oe_o[i]  = pwm_en_i[i] | dir_q_i[i];
    end else begin : g_plain
      assign pin_out_o[i] = data_q_i[i];
      assign pin_oe_o[i]  = dir_q_i[i];
    end
  end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux #(
  parameter int WIDTH = 8
) (
  input  logic             sel_i,
  input  logic [WIDTH-1:0] data_q_i,
  input  logic [WIDTH-1:0] dir_q_i,
  input  logic [WIDTH-1:0] pin_in_i,
  output logic [WIDTH-1:0] rdata_o
);
  import gpio_pkg::*;

  logic [WIDTH-1:0] data_view;
  // outputs report the latch, inputs report the pad
  assign data_view = (dir_q_i & data_q_i) | (~dir_q_i & pin_in_i);

  always_comb begin
    unique case (reg_sel_e'(sel_i))
      REG_DIR: rdata_o = dir_q_i;
      default: rdata_o = data_view;
    endcase
  end
endmodule

// File: rtl/gpio_pwm_port.sv
module gpio_pwm_port #(
  parameter int WIDTH   = 8,
  parameter int NUM_PWM = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               sel_i,
  input  logic [WIDTH-1:0]   wdata_i,
  output logic [WIDTH-1:0]   rdata_o,
  input  logic [NUM_PWM-1:0] pwm_en_i,
  input  logic [NUM_PWM-1:0] pwm_val_i,
  input  logic [WIDTH-1:0]   pin_in_i,
  output logic [WIDTH-1:0]   pin_out_o,
  output logic [WIDTH-1:0]   pin_oe_o
);
  logic [WIDTH-1:0] data_q, dir_q;

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .sel_i    (sel_i),
    .wdata_i  (wdata_i),
    .data_q_o (data_q),
    .dir_q_o  (dir_q)
  );

  gpio_pin_mux #(.WIDTH(WIDTH), .NUM_PWM(NUM_PWM)) u_mux (
    .data_q_i  (data_q),
    .dir_q_i   (dir_q),
    .pwm_en_i  (pwm_en_i),
    .pwm_val_i (pwm_val_i),
    .pin_out_o (pin_out_o),
    .pin_oe_o  (pin_oe_o)
  );

  gpio_read_mux #(.WIDTH(WIDTH)) u_rd (
    .sel_i    (sel_i),
    .data_q_i (data_q),
    .dir_q_i  (dir_q),
    .pin_in_i (pin_in_i),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/gpio_pwm_port_chk.sv
module gpio_pwm_port_chk #(
  parameter int WIDTH   = 8,
  parameter int NUM_PWM = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic               sel_i,
  input logic [WIDTH-1:0]   wdata_i,
  input logic [WIDTH-1:0]   rdata_o,
  input logic [NUM_PWM-1:0] pwm_en_i,
  input logic [NUM_PWM-1:0] pwm_val_i,
  input logic [WIDTH-1:0]   pin_in_i,
  input logic [WIDTH-1:0]   pin_out_o,
  input logic [WIDTH-1:0]   pin_oe_o,
  input logic [WIDTH-1:0]   data_q,
  input logic [WIDTH-1:0]   dir_q
);
  AST_DIR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i) |=> (rdata_o == $past(wdata_i)) || !sel_i); // R2

  AST_LATCH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !sel_i) |=> data_q == $past(wdata_i)); // R7

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    AST_READ_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sel_i && !dir_q[i]) |-> rdata_o[i] == pin_in_i[i]); // R3

    AST_READ_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sel_i && dir_q[i]) |-> rdata_o[i] == data_q[i]); // R4

    if (i < NUM_PWM) begin : g_pwm
      AST_PWM_OWNS_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwm_en_i[i] |-> (pin_out_o[i] == pwm_val_i[i]) && pin_oe_o[i]); // R6

      AST_PWM_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(pwm_en_i[i]) && dir_q[i]) |-> pin_out_o[i] == data_q[i]); // R8

      AST_IDLE_UNDRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pwm_en_i[i] && !dir_q[i]) |-> !pin_oe_o[i]); // R10
    end else begin : g_gp
      AST_IDLE_UNDRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dir_q[i] |-> !pin_oe_o[i]); // R10
    end
  end
endmodule

bind gpio_pwm_port gpio_pwm_port_chk #(.WIDTH(WIDTH), .NUM_PWM(NUM_PWM)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .sel_i     (sel_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pwm_en_i  (pwm_en_i),
  .pwm_val_i (pwm_val_i),
  .pin_in_i  (pin_in_i),
  .pin_out_o (pin_out_o),
  .pin_oe_o  (pin_oe_o),
  .data_q    (data_q),
  .dir_q     (dir_q)
);

// File: tb/sim_gpio_pwm_port.sv
module sim_gpio_pwm_port;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       sel_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [3:0] pwm_en_i = '0;
  logic [3:0] pwm_val_i = '0;
  logic [7:0] pin_in_i = 8'hA5;
  logic [7:0] pin_out_o;
  logic [7:0] pin_oe_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference state
  logic [7:0] m_data = '0;
  logic [7:0] m_dir = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_pwm_port u0 (
    .clk_i, .rst_ni, .wr_en_i, .sel_i, .wdata_i, .rdata_o,
    .pwm_en_i, .pwm_val_i, .pin_in_i, .pin_out_o, .pin_oe_o
  );

  task automatic check8(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    logic [7:0] e_out, e_oe, e_rd;
    e_out = m_data;
    e_oe  = m_dir;
    for (int i = 0; i < 4; i++) begin
      if (pwm_en_i[i]) begin
        e_out[i] = pwm_val_i[i];
        e_oe[i]  = 1'b1;
      end
    end
    e_rd = sel_i ? m_dir : ((m_dir & m_data) | (~m_dir & pin_in_i));
    check8(tag, "pin_out", pin_out_o, e_out);
    check8(tag, "pin_oe", pin_oe_o, e_oe);
    check8(tag, "rdata", rdata_o, e_rd);
  endtask

  // inputs applied at falling edge, model updated at rising edge, compare at next falling edge
  task automatic cyc(bit wr, bit sel, logic [7:0] wd, logic [3:0] pen, logic [3:0] pval,
                     logic [7:0] pin, string tag);
    wr_en_i = wr; sel_i = sel; wdata_i = wd;
    pwm_en_i = pen; pwm_val_i = pval; pin_in_i = pin;
    @(posedge clk_i);
    if (wr) begin
      if (sel) m_dir = wd;
      else     m_data = wd;
    end
    @(negedge clk_i);
    wr_en_i = 1'b0;
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] lf;
    #(CLK_PERIOD * 2);
    @(negedge clk_i);
    compare("R1");
    sel_i = 1'b1;
    #1 check8("R1", "dir readback", rdata_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);

    cyc(1, 1, 8'hF0, 4'h0, 4'h0, 8'hA5, "R2");
    cyc(0, 1, 8'h00, 4'h0, 4'h0, 8'hA5, "R2");
    cyc(1, 0, 8'h3C, 4'h0, 4'h0, 8'hA5, "R5");
    cyc(0, 0, 8'h00, 4'h0, 4'h0, 8'h0F, "R3");
    cyc(0, 0, 8'h00, 4'h0, 4'h0, 8'h0F, "R10");
    cyc(0, 0, 8'h00, 4'h5, 4'h1, 8'h0F, "R6");
    cyc(1, 1, 8'hFF, 4'h5, 4'h1, 8'h0F, "R4");
    cyc(1, 0, 8'hC3, 4'h5, 4'h1, 8'h00, "R7");
    cyc(0, 0, 8'h00, 4'hF, 4'hA, 8'h00, "R7");
    cyc(0, 0, 8'h00, 4'hF, 4'h5, 8'hFF, "R6");
    cyc(0, 0, 8'h00, 4'h0, 4'h5, 8'hFF, "R8");
    cyc(1, 1, 8'h00, 4'h0, 4'h0, 8'hFF, "R10");
    cyc(1, 0, 8'h5A, 4'h0, 4'h0, 8'h81, "R9");
    cyc(1, 1, 8'hFF, 4'h0, 4'h0, 8'h81, "R9");
    cyc(1, 1, 8'h00, 4'h3, 4'h2, 8'h81, "R6");
    cyc(0, 0, 8'h00, 4'h0, 4'h2, 8'h81, "R8");
    cyc(1, 1, 8'h0F, 4'h6, 4'h6, 8'h81, "R6");
    cyc(0, 0, 8'h00, 4'h0, 4'h6, 8'h81, "R8");

    lf = 8'h1D;
    for (int k = 0; k < 24; k++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      cyc(lf[0], lf[1], lf ^ 8'h96, lf[7:4], lf[3:0], ~lf, "R5");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule